// File: doc/BRIEF.md
# Packed Byte Rounding Averager

This block averages unsigned pixel bytes that are packed side by side in one word. Each byte lane is handled on its own, and carries never cross from one lane into the next. The block has two modes. Pair mode takes two packed words and returns the half-sum of each lane. That half-sum is either rounded up or truncated. Quad mode averages four pixels per lane. It does not take the raw pixels. It takes two pair half-sums and two pair XOR words, which are the intermediate terms a row filter produces. A caller can therefore compute a row's terms once and use them for the row above and for the row below.

The rounding control is active-low: `no_round` = 0 asks for rounding and `no_round` = 1 asks for truncation. Inputs are captured on a clock edge while `in_vld` is high. The result is registered and appears one cycle later, flagged by `out_vld`.

Top module: `pkavg_top`

## Requirements
- R1: While reset is applied, and on the first edge after it is released, `out_vld` is 0 and `result` is 0.
- R2: Pair mode is selected by `mode` = 0. With `no_round` = 0, each 8-bit lane of `result` is (a + b + 1) >> 1, where a is the lane of `op_a` and b is the lane of `op_b`. The sum is taken at 9 bits.
- R3: In pair mode with `no_round` = 1, each lane of `result` is (a + b) >> 1.
- R4: Quad mode is selected by `mode` = 1. The inputs are mapped as follows: `op_a` carries s0 = (a+b)>>1, `op_b` carries l0 = a^b, `op_c` carries s1 = (c+d)>>1 and `op_d` carries l1 = c^d. Only bit 0 of each lane of `op_b` and `op_d` affects the result.
- R5: In quad mode with `no_round` = 0, each lane of `result` equals (a+b+c+d+2) >> 2.
- R6: In quad mode with `no_round` = 1, each lane of `result` equals (a+b+c+d+1) >> 2.
- R7: In quad mode each lane is ((s0+s1)>>1) + e2, taken modulo 256 with no saturation. Here p = (s0^s1) bit 0. With rounding, e2 = (l0&l1 bit 0) | p. Without rounding, e2 = (l0|l1 bit 0) & p.
- R8: Lanes are independent. A lane result of 0 or 255 leaves the neighbouring lanes unchanged.
- R9: The result of inputs sampled on an edge with `in_vld` = 1 appears after that edge. `out_vld` equals `in_vld` delayed by one cycle.
- R10: On an edge where `in_vld` = 0, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Input-capture enable |
| mode | input | 1 | 0 = pair mode, 1 = quad mode |
| no_round | input | 1 | 0 = round, 1 = truncate |
| op_a | input | LANES*LANE_W | Pair operand a, or quad s0 |
| op_b | input | LANES*LANE_W | Pair operand b, or quad l0 |
| op_c | input | LANES*LANE_W | Quad s1 (ignored in pair mode) |
| op_d | input | LANES*LANE_W | Quad l1 (ignored in pair mode) |
| out_vld | output | 1 | Result valid |
| result | output | LANES*LANE_W | Packed averaged lanes |

## Verification
The quad-mode assertions assume the caller supplies consistent terms. For the identity checks, that means equal half-sums and zero XOR low bits. The pair-mode assertions only need equal operands or a zero second operand, so they hold for any word.

Random quad stimulus is always built from real pixels a, b, c and d. Those pixels are folded into s0, l0, s1 and l1 before they are applied, so the four-pixel reference formula remains valid. The modulo-256 wrap of R7 needs half-sums that no real pixel pair can produce, so it is exercised by a directed case.

// File: rtl/pkavg_pkg.sv
package pkavg_pkg;
  typedef enum logic {
    AVG_PAIR = 1'b0,
    AVG_QUAD = 1'b1
  } avg_mode_e;
endpackage

// File: rtl/pkavg_rst_sync.sv
module pkavg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/pkavg_pair_lane.sv
module pkavg_pair_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] x,
  input  logic [LANE_W-1:0] y,
  input  logic              rnd_en,
  output logic [LANE_W-1:0] z
);
  logic [LANE_W:0] sum;

  always_comb begin
    sum = {1'b0, x} + {1'b0, y} + {{LANE_W{1'b0}}, rnd_en};
    z   = sum[LANE_W:1];
  end
endmodule

// File: rtl/pkavg_quad_lane.sv
module pkavg_quad_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] s0,
  input  logic              l0_lsb,
  input  logic [LANE_W-1:0] s1,
  input  logic              l1_lsb,
  input  logic              rnd_en,
  output logic [LANE_W-1:0] z
);
  logic [LANE_W:0]   half_sum;
  logic              par;
  logic              e2;

  always_comb begin
    half_sum = {1'b0, s0} + {1'b0, s1};
    par      = s0[0] ^ s1[0];
    if (rnd_en) e2 = (l0_lsb & l1_lsb) | par;
    else        e2 = (l0_lsb | l1_lsb) & par;
    z = half_sum[LANE_W:1] + {{(LANE_W-1){1'b0}}, e2};
  end
endmodule

// File: rtl/pkavg_top.sv
module pkavg_top #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic                      mode,
  input  logic                      no_round,
  input  logic [LANES*LANE_W-1:0]   op_a,
  input  logic [LANES*LANE_W-1:0]   op_b,
  input  logic [LANES*LANE_W-1:0]   op_c,
  input  logic [LANES*LANE_W-1:0]   op_d,
  output logic                      out_vld,
  output logic [LANES*LANE_W-1:0]   result
);
  import pkavg_pkg::*;

  localparam int WORD_W = LANES * LANE_W;

  logic              rst_n_sync;
  logic              rnd_en;
  avg_mode_e         mode_sel;
  logic [WORD_W-1:0] pair_word;
  logic [WORD_W-1:0] quad_word;
  logic [WORD_W-1:0] result_d;
  logic              out_vld_d;

  pkavg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign rnd_en   = ~no_round;
  assign mode_sel = avg_mode_e'(mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pkavg_pair_lane #(.LANE_W(LANE_W)) u_pair (
      .x      (op_a[g*LANE_W +: LANE_W]),
      .y      (op_b[g*LANE_W +: LANE_W]),
      .rnd_en (rnd_en),
      .z      (pair_word[g*LANE_W +: LANE_W])
    );
    pkavg_quad_lane #(.LANE_W(LANE_W)) u_quad (
      .s0     (op_a[g*LANE_W +: LANE_W]),
      .l0_lsb (op_b[g*LANE_W]),
      .s1     (op_c[g*LANE_W +: LANE_W]),
      .l1_lsb (op_d[g*LANE_W]),
      .rnd_en (rnd_en),
      .z      (quad_word[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    out_vld_d = in_vld;
    result_d  = result;
    if (in_vld) begin
      result_d = (mode_sel == AVG_QUAD) ? quad_word : pair_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      out_vld <= 1'b0;
      result  <= '0;
    end else begin
      out_vld <= out_vld_d;
      result  <= result_d;
    end
  end
endmodule

// File: rtl/pkavg_chk.sv
module pkavg_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic                    mode,
  input logic                    no_round,
  input logic [LANES*LANE_W-1:0] op_a,
  input logic [LANES*LANE_W-1:0] op_b,
  input logic [LANES*LANE_W-1:0] op_c,
  input logic [LANES*LANE_W-1:0] op_d,
  input logic                    out_vld,
  input logic [LANES*LANE_W-1:0] result
);
  localparam int WORD_W = LANES * LANE_W;

  function automatic logic [WORD_W-1:0] lsb_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) m[i*LANE_W] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] lane_half(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = w[i*LANE_W +: LANE_W] >> 1;
    return r;
  endfunction

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);  // R9
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(result));  // R10
  AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !mode && op_a == op_b) |=> result == $past(op_a));  // R2
  AST_PAIR_TRUNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !mode && no_round && op_b == '0) |=> result == lane_half($past(op_a)));  // R3
  AST_QUAD_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode && op_a == op_c && (op_b & lsb_mask()) == '0 && (op_d & lsb_mask()) == '0)
      |=> result == $past(op_a));  // R4
endmodule

bind pkavg_top pkavg_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .no_round(no_round),
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
  .out_vld(out_vld), .result(result)
);

// File: tb/sim_pkavg_top.sv
`timescale 1ns/1ps
module sim_pkavg_top;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  logic              clk;
  logic              rst_n;
  logic              in_vld;
  logic              mode;
  logic              no_round;
  logic [WORD_W-1:0] op_a, op_b, op_c, op_d;
  logic              out_vld;
  logic [WORD_W-1:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  pkavg_top #(.LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .no_round(no_round),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .out_vld(out_vld), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] ref_pair(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b, input bit nr);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int s;
      s = int'(a[i*LANE_W +: LANE_W]) + int'(b[i*LANE_W +: LANE_W]) + (nr ? 0 : 1);
      r[i*LANE_W +: LANE_W] = LANE_W'(s / 2);
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] ref_quad(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                                                  input logic [WORD_W-1:0] c, input logic [WORD_W-1:0] d, input bit nr);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int s;
      s = int'(a[i*LANE_W +: LANE_W]) + int'(b[i*LANE_W +: LANE_W]) +
          int'(c[i*LANE_W +: LANE_W]) + int'(d[i*LANE_W +: LANE_W]) + (nr ? 1 : 2);
      r[i*LANE_W +: LANE_W] = LANE_W'(s / 4);
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] half_sum_w(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*LANE_W +: LANE_W] = LANE_W'((int'(a[i*LANE_W +: LANE_W]) + int'(b[i*LANE_W +: LANE_W])) / 2);
    return r;
  endfunction

  // Drive at negedge, capture at posedge, sample at the following negedge.
  task automatic apply(input bit md, input bit nr, input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                       input logic [WORD_W-1:0] c, input logic [WORD_W-1:0] d);
    in_vld = 1'b1; mode = md; no_round = nr;
    op_a = a; op_b = b; op_c = c; op_d = d;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic pair_case(input string req, input bit nr, input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    apply(1'b0, nr, a, b, $urandom, $urandom);
    check(req, result, ref_pair(a, b, nr));
  endtask

  task automatic quad_case(input string req, input bit nr, input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                           input logic [WORD_W-1:0] c, input logic [WORD_W-1:0] d);
    apply(1'b1, nr, half_sum_w(a, b), a ^ b, half_sum_w(c, d), c ^ d);
    check(req, result, ref_quad(a, b, c, d, nr));
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_vld = 1'b0; mode = 1'b0; no_round = 1'b0;
    op_a = '0; op_b = '0; op_c = '0; op_d = '0;
    repeat (3) @(negedge clk);
    check("R1 result", result, '0);
    check("R1 out_vld", {31'd0, out_vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'd0, out_vld}, '0);
    repeat (2) @(negedge clk);

    // R9: valid timing
    apply(1'b0, 1'b0, 32'h0102_0304, 32'h0102_0304, '0, '0);
    check("R9 out_vld high", {31'd0, out_vld}, 32'd1);
    @(negedge clk);
    check("R9 out_vld low", {31'd0, out_vld}, '0);

    // R2/R3 pair directed corners
    pair_case("R2 all ff", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    pair_case("R2 odd sums", 1'b0, 32'h00FF_0100, 32'h01FE_0001);
    pair_case("R3 odd sums", 1'b1, 32'h00FF_0100, 32'h01FE_0001);
    pair_case("R3 zero/ff", 1'b1, 32'hFF00_FF00, 32'h00FF_FF00);
    // R8 lane independence: saturating lane next to zero lanes
    pair_case("R8 lane isolation", 1'b0, 32'h00FF_00FF, 32'h00FF_0001);

    // R5/R6 quad corners
    quad_case("R5 all ff", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    quad_case("R6 all zero", 1'b1, '0, '0, '0, '0);
    quad_case("R5 mixed", 1'b0, 32'h00FF_0102, 32'hFF00_0001, 32'h00FF_0300, 32'hFF01_0001);
    quad_case("R6 mixed", 1'b1, 32'h00FF_0102, 32'hFF00_0001, 32'h00FF_0300, 32'hFF01_0001);

    // R4: only bit 0 of l0/l1 lanes matter
    apply(1'b1, 1'b0, 32'h1020_3040, 32'hFEFE_FEFE, 32'h1121_3141, 32'hFEFE_FEFE);
    check("R4 upper xor bits ignored", result, 32'h1121_3141);

    // R7: wrap modulo 256 without saturation
    apply(1'b1, 1'b0, 32'hFF00_FF00, 32'h0100_0100, 32'hFF00_FF00, 32'h0100_0100);
    check("R7 wrap", result, 32'h0000_0000);
    apply(1'b1, 1'b1, 32'hFE00_FF00, 32'h0100_0000, 32'hFF00_FF00, 32'h0000_0000);
    check("R7 truncate carry", result, 32'hFF00_FF00);

    // R10: hold while idle
    op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; mode = 1'b0; in_vld = 1'b0;
    @(negedge clk);
    check("R10 hold", result, 32'hFF00_FF00);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [WORD_W-1:0] a, b, c, d;
      bit nr;
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      nr = 1'($urandom);
      if (k % 2 == 0) pair_case(nr ? "R3 random" : "R2 random", nr, a, b);
      else            quad_case(nr ? "R6 random" : "R5 random", nr, a, b, c, d);
    end

    finish_up();
  end
endmodule